// File: doc/BRIEF.md
# Profile-Selected DDS Phase Accumulator

This block is the digital front end of one direct digital synthesis channel. Every clock it adds a frequency tuning word to a 32-bit phase accumulator. It adds a 14-bit phase offset to the top of the accumulator and presents the sum as a registered phase word. It also presents a registered 10-bit amplitude scale word. A sine lookup and a converter further down the chain turn these two words into a waveform.

Software writes the configuration through a simple write port into a shadow copy. The whole shadow copy moves to the active set only when a one-cycle I/O update strobe arrives, so a multi-word change takes effect in a single cycle. In modulation mode, a level count of 2, 4, 8 or 16 masks the profile pins. The masked value picks which of sixteen levels drives the frequency, the phase or the amplitude: level 0 is the base word, and levels 1 to 15 come from the profile registers. Two accumulator clear behaviours are provided. Clear-and-hold keeps the accumulator at zero for as long as its bit is set. Auto-clear zeroes the accumulator once after each I/O update and then lets it run again.

Top module: `dds_profile_core`

## Requirements
- R1: While `rst` is high at a clock edge, all shadow and active registers, the accumulator, `phase_out` and `amp_out` become zero.
- R2: The write address map is as follows. 0 holds the base tuning word (32 bits). 1 holds the base phase offset (low 14 bits). 2 holds the base amplitude (low 10 bits). 3 holds control. 16+k holds profile k for k = 1..15, and 16 is reserved and is never selected. A write changes only the shadow copy; outputs keep their old behaviour until an `io_update` pulse copies every shadow word into the active set at that edge.
- R3: Unless a clear is in force, the accumulator adds the selected tuning word on every clock and wraps modulo 2^32.
- R4: `phase_out` equals the top 14 bits of the accumulator plus the selected phase offset, modulo 2^14, registered one clock after the accumulator value it is built from.
- R5: `amp_out` equals the selected 10-bit amplitude word, registered one clock after selection.
- R6: Control bits [1:0] select the modulated parameter: 0 none, 1 frequency, 2 phase, 3 amplitude. In frequency mode, a masked profile index k other than 0 takes the tuning word from profile k, and index 0 takes the base tuning word.
- R7: In phase mode, a masked index k other than 0 takes the phase offset from the low 14 bits of profile k, and index 0 takes the base offset.
- R8: In amplitude mode, a masked index k other than 0 takes the amplitude from the low 10 bits of profile k, and index 0 takes the base amplitude.
- R9: Control bits [3:2] set the level count as 2, 4, 8 or 16 (codes 0 to 3). The profile index is the registered `profile_sel` with every pin above that count forced to zero.
- R10: With the parameter code at 0 (none), `profile_sel` has no effect on either output.
- R11: While control bit 4 (clear-and-hold) is active, the accumulator is zero, so `phase_out` equals the selected phase offset.
- R12: When the active control has bit 5 (auto-clear) set, the accumulator is forced to zero on the clock after each `io_update` pulse and then resumes accumulating from zero.
- R13: A write issued in the same cycle as an `io_update` pulse is not part of that update; it takes effect on the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | 5 | Shadow register address |
| wr_data | input | 32 | Write data |
| io_update | input | 1 | One-cycle pulse that commits the shadow set |
| profile_sel | input | 4 | Profile pins, masked by the level count |
| phase_out | output | 14 | Truncated phase plus offset |
| amp_out | output | 10 | Amplitude scale word |

## Verification
The bench steps the profile pins through all sixteen values under each level count. A design that masked the pins wrongly would select a profile above the level count and jump to a wrong tuning word or offset. The bench also keeps the pins moving in single-tone mode, where a leak would show up as phase or amplitude jitter. Writes before an update, and a write that coincides with an update, expose any path that lets shadow data reach the outputs early. A tuning word near full scale forces accumulator wrap-around. The two clears are run back to back: a hold that released too early would let the phase creep away from the bare offset, and an auto-clear that fired for more than one cycle, or only on the first update, would put the accumulator out of step with the reference.

// File: rtl/dds_prof_pkg.sv
package dds_prof_pkg;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'd0,
    MOD_FREQ  = 2'd1,
    MOD_PHASE = 2'd2,
    MOD_AMP   = 2'd3
  } mod_e;

  // bit 5 auto-clear, bit 4 clear-and-hold, bits 3:2 level code, bits 1:0 mode
  typedef struct packed {
    logic       auto_clr;
    logic       hold;
    logic [1:0] lvl;
    mod_e       mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam int unsigned ADR_FTW  = 0;
  localparam int unsigned ADR_POW  = 1;
  localparam int unsigned ADR_ASF  = 2;
  localparam int unsigned ADR_CTRL = 3;

endpackage

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_prof_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned AMP_W   = 10,
  parameter int unsigned NPROF   = 16,
  parameter int unsigned ADDR_W  = $clog2(2 * NPROF),
  parameter int unsigned PIDX_W  = $clog2(NPROF)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           io_update,
  output logic [DATA_W-1:0]              act_ftw,
  output logic [PHASE_W-1:0]             act_pow,
  output logic [AMP_W-1:0]               act_asf,
  output ctrl_t                          act_ctrl,
  output logic [NPROF-1:0][DATA_W-1:0]   act_prof
);

  logic              prof_hit;
  logic [PIDX_W-1:0] prof_idx;
  logic              base_hit;

  assign prof_hit = wr_en && wr_addr[ADDR_W-1];
  assign base_hit = wr_en && !wr_addr[ADDR_W-1];
  assign prof_idx = wr_addr[PIDX_W-1:0];

  logic [DATA_W-1:0]  sh_ftw;
  logic [PHASE_W-1:0] sh_pow;
  logic [AMP_W-1:0]   sh_asf;
  ctrl_t              sh_ctrl;

  // shadow base registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ftw  <= '0;
      sh_pow  <= '0;
      sh_asf  <= '0;
      sh_ctrl <= '0;
    end else if (base_hit) begin
      case (int'(wr_addr))
        ADR_FTW:  sh_ftw  <= wr_data;
        ADR_POW:  sh_pow  <= wr_data[PHASE_W-1:0];
        ADR_ASF:  sh_asf  <= wr_data[AMP_W-1:0];
        ADR_CTRL: sh_ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  // active base registers, loaded as a set on the update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ftw  <= '0;
      act_pow  <= '0;
      act_asf  <= '0;
      act_ctrl <= '0;
    end else if (io_update) begin
      act_ftw  <= sh_ftw;
      act_pow  <= sh_pow;
      act_asf  <= sh_asf;
      act_ctrl <= sh_ctrl;
    end
  end

  // profile entries, one shadow/active pair each
  for (genvar k = 0; k < NPROF; k++) begin : g_prof
    logic [DATA_W-1:0] sh_word;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_word     <= '0;
        act_prof[k] <= '0;
      end else begin
        if (prof_hit && (prof_idx == PIDX_W'(k)))
          sh_word <= wr_data;
        if (io_update)
          act_prof[k] <= sh_word;
      end
    end
  end

endmodule

// File: rtl/dds_profile_mux.sv
module dds_profile_mux
  import dds_prof_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned AMP_W   = 10,
  parameter int unsigned NPROF   = 16,
  parameter int unsigned PIDX_W  = $clog2(NPROF)
) (
  input  logic [DATA_W-1:0]            act_ftw,
  input  logic [PHASE_W-1:0]           act_pow,
  input  logic [AMP_W-1:0]             act_asf,
  input  ctrl_t                        act_ctrl,
  input  logic [NPROF-1:0][DATA_W-1:0] act_prof,
  input  logic [PIDX_W-1:0]            pins,
  output logic [DATA_W-1:0]            ftw_sel,
  output logic [PHASE_W-1:0]           pow_sel,
  output logic [AMP_W-1:0]             asf_sel
);

  logic [PIDX_W-1:0] mask;
  logic [PIDX_W-1:0] idx;
  logic [DATA_W-1:0] entry;
  logic              use_prof;

  // level code n keeps pins 0..n (2 << n levels)
  always_comb begin
    for (int i = 0; i < PIDX_W; i++)
      mask[i] = (i <= int'(act_ctrl.lvl));
  end

  assign idx      = pins & mask;
  assign entry    = act_prof[idx];
  assign use_prof = (idx != '0);

  always_comb begin
    ftw_sel = act_ftw;
    pow_sel = act_pow;
    asf_sel = act_asf;
    if (use_prof) begin
      case (act_ctrl.mode)
        MOD_FREQ:  ftw_sel = entry;
        MOD_PHASE: pow_sel = entry[PHASE_W-1:0];
        MOD_AMP:   asf_sel = entry[AMP_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic             hold_clr,
  input  logic             pulse_clr,
  output logic [ACC_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst || hold_clr || pulse_clr)
      acc_q <= '0;
    else
      acc_q <= acc_q + ftw;
  end

endmodule

// File: rtl/dds_out_stage.sv
module dds_out_stage #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   acc_q,
  input  logic [PHASE_W-1:0] pow_sel,
  input  logic [AMP_W-1:0]   asf_sel,
  output logic [PHASE_W-1:0] phase_out,
  output logic [AMP_W-1:0]   amp_out
);

  logic [PHASE_W-1:0] acc_top;
  assign acc_top = acc_q[ACC_W-1 -: PHASE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_out <= '0;
      amp_out   <= '0;
    end else begin
      phase_out <= acc_top + pow_sel;
      amp_out   <= asf_sel;
    end
  end

endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core
  import dds_prof_pkg::*;
#(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned AMP_W   = 10,
  parameter int unsigned NPROF   = 16,
  localparam int unsigned ADDR_W = $clog2(2 * NPROF),
  localparam int unsigned PIDX_W = $clog2(NPROF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ACC_W-1:0]   wr_data,
  input  logic               io_update,
  input  logic [PIDX_W-1:0]  profile_sel,
  output logic [PHASE_W-1:0] phase_out,
  output logic [AMP_W-1:0]   amp_out
);

  logic [ACC_W-1:0]            act_ftw;
  logic [PHASE_W-1:0]          act_pow;
  logic [AMP_W-1:0]            act_asf;
  ctrl_t                       act_ctrl;
  logic [NPROF-1:0][ACC_W-1:0] act_prof;

  logic [PIDX_W-1:0]           prof_q;
  logic                        upd_q;
  logic [ACC_W-1:0]            ftw_sel;
  logic [PHASE_W-1:0]          pow_sel;
  logic [AMP_W-1:0]            asf_sel;
  logic [ACC_W-1:0]            acc_q;
  logic                        act_hold;
  logic                        act_auto;

  assign act_hold = act_ctrl.hold;
  assign act_auto = act_ctrl.auto_clr;

  // register the profile pins and the update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      prof_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      prof_q <= profile_sel;
      upd_q  <= io_update;
    end
  end

  dds_regbank #(
    .DATA_W (ACC_W),
    .PHASE_W(PHASE_W),
    .AMP_W  (AMP_W),
    .NPROF  (NPROF),
    .ADDR_W (ADDR_W),
    .PIDX_W (PIDX_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .io_update(io_update),
    .act_ftw  (act_ftw),
    .act_pow  (act_pow),
    .act_asf  (act_asf),
    .act_ctrl (act_ctrl),
    .act_prof (act_prof)
  );

  dds_profile_mux #(
    .DATA_W (ACC_W),
    .PHASE_W(PHASE_W),
    .AMP_W  (AMP_W),
    .NPROF  (NPROF),
    .PIDX_W (PIDX_W)
  ) u_mux (
    .act_ftw (act_ftw),
    .act_pow (act_pow),
    .act_asf (act_asf),
    .act_ctrl(act_ctrl),
    .act_prof(act_prof),
    .pins    (prof_q),
    .ftw_sel (ftw_sel),
    .pow_sel (pow_sel),
    .asf_sel (asf_sel)
  );

  dds_phase_accum #(
    .ACC_W(ACC_W)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .ftw      (ftw_sel),
    .hold_clr (act_hold),
    .pulse_clr(upd_q & act_auto),
    .acc_q    (acc_q)
  );

  dds_out_stage #(
    .ACC_W  (ACC_W),
    .PHASE_W(PHASE_W),
    .AMP_W  (AMP_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .acc_q    (acc_q),
    .pow_sel  (pow_sel),
    .asf_sel  (asf_sel),
    .phase_out(phase_out),
    .amp_out  (amp_out)
  );

endmodule

// File: rtl/dds_profile_chk.sv
module dds_profile_chk #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned AMP_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               io_update,
  input logic               upd_q,
  input logic               act_hold,
  input logic               act_auto,
  input logic [ACC_W-1:0]   act_ftw,
  input logic [ACC_W-1:0]   ftw_sel,
  input logic [PHASE_W-1:0] pow_sel,
  input logic [AMP_W-1:0]   asf_sel,
  input logic [ACC_W-1:0]   acc_q,
  input logic [PHASE_W-1:0] phase_out,
  input logic [AMP_W-1:0]   amp_out
);

  logic [PHASE_W-1:0] acc_top;
  assign acc_top = acc_q[ACC_W-1 -: PHASE_W];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && amp_out == '0 && acc_q == '0));

  // R2
  commit_only_chk: assert property (@(posedge clk) disable iff (rst)
    !io_update |=> $stable(act_ftw));

  // R3
  accumulate_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_hold && !(upd_q && act_auto)) |=>
      acc_q == ACC_W'($past(acc_q) + $past(ftw_sel)));

  // R4
  phase_sum_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_out == PHASE_W'($past(acc_top) + $past(pow_sel)));

  // R5
  amp_path_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> amp_out == $past(asf_sel));

  // R11
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    act_hold |=> acc_q == '0);

  // R12
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && act_auto) |=> acc_q == '0);

endmodule

bind dds_profile_core dds_profile_chk #(
  .ACC_W  (ACC_W),
  .PHASE_W(PHASE_W),
  .AMP_W  (AMP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_update(io_update),
  .upd_q    (upd_q),
  .act_hold (act_hold),
  .act_auto (act_auto),
  .act_ftw  (act_ftw),
  .ftw_sel  (ftw_sel),
  .pow_sel  (pow_sel),
  .asf_sel  (asf_sel),
  .acc_q    (acc_q),
  .phase_out(phase_out),
  .amp_out  (amp_out)
);

// File: tb/sim_dds_profile_core.sv
module sim_dds_profile_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        io_update = 1'b0;
  logic [3:0]  profile_sel = '0;
  logic [13:0] phase_out;
  logic [9:0]  amp_out;

  always #2 clk = ~clk;

  dds_profile_core u0 (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .io_update  (io_update),
    .profile_sel(profile_sel),
    .phase_out  (phase_out),
    .amp_out    (amp_out)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference, keyed by write address
  logic [31:0] m_sh [32];
  logic [31:0] m_ac [32];
  logic [31:0] m_acc = '0;
  logic [13:0] m_phase = '0;
  logic [9:0]  m_amp = '0;
  logic [3:0]  m_prof = '0;
  logic        m_upd = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int i = 0; i < 32; i++) begin
        m_sh[i] = '0;
        m_ac[i] = '0;
      end
      m_acc = '0; m_phase = '0; m_amp = '0; m_prof = '0; m_upd = 1'b0;
    end else begin
      int          mode, lvl, idx;
      logic        hold, autoc;
      logic [31:0] f;
      logic [13:0] p;
      logic [9:0]  a;
      mode  = int'(m_ac[3][1:0]);
      lvl   = int'(m_ac[3][3:2]);
      hold  = m_ac[3][4];
      autoc = m_ac[3][5];
      idx   = int'(m_prof) % (2 << lvl);
      f = m_ac[0];
      p = m_ac[1][13:0];
      a = m_ac[2][9:0];
      if (idx != 0) begin
        if (mode == 1) f = m_ac[16 + idx];
        if (mode == 2) p = m_ac[16 + idx][13:0];
        if (mode == 3) a = m_ac[16 + idx][9:0];
      end
      m_phase = m_acc[31:18] + p;
      m_amp   = a;
      if (hold || (m_upd && autoc)) m_acc = '0;
      else m_acc = m_acc + f;
      if (io_update)
        for (int i = 0; i < 32; i++) m_ac[i] = m_sh[i];
      if (wr_en) m_sh[wr_addr] = wr_data;
      m_prof = profile_sel;
      m_upd  = io_update;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (phase_out !== m_phase || amp_out !== m_amp) begin
        n_fail++;
        $display("FAIL %s cycle %0d: phase_out=%h amp_out=%h expected phase=%h amp=%h",
                 cur_req, cyc, phase_out, amp_out, m_phase, m_amp);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk);
    io_update = 1'b1;
    @(negedge clk);
    io_update = 1'b0;
  endtask

  task automatic sweep_pins(input int hold_cycles);
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      profile_sel = 4'(s);
      idle(hold_cycles);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int mode, input int lvl,
                                            input bit hold, input bit autoc);
    return 32'(mode) | (32'(lvl) << 2) | (32'(hold) << 4) | (32'(autoc) << 5);
  endfunction

  // summary printed once, from the main flow or the watchdog
  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      finish_run();
    end
  end

  initial begin
    idle(4);
    cur_req = "R1";
    chk("R1", 32'(phase_out), 32'h0);
    chk("R1", 32'(amp_out), 32'h0);
    rst = 1'b0;

    // R2: writes stay in the shadow copy until the update strobe
    cur_req = "R2";
    wr(5'd0, 32'h0100_0000);
    wr(5'd1, 32'h0000_0123);
    wr(5'd2, 32'h0000_03FF);
    wr(5'd3, ctrl_word(0, 0, 0, 0));
    idle(4);
    chk("R2", 32'(amp_out), 32'h0);
    chk("R2", 32'(phase_out), 32'h0);
    upd();
    cur_req = "R3";
    idle(20);
    chk("R5", 32'(amp_out), 32'h3FF);

    // R3: wrap of the accumulator near full scale
    wr(5'd0, 32'hF000_0001);
    upd();
    cur_req = "R4";
    idle(24);

    // profile words
    for (int k = 1; k < 16; k++)
      wr(5'(16 + k), 32'h0111_1111 * 32'(k) + 32'h0000_0A5A + 32'(k * 37));
    wr(5'd0, 32'h0040_0000);

    // R6 and R9: frequency mode, four levels
    wr(5'd3, ctrl_word(1, 1, 0, 0));
    upd();
    cur_req = "R9";
    sweep_pins(3);
    // R6: sixteen levels
    wr(5'd3, ctrl_word(1, 3, 0, 0));
    upd();
    cur_req = "R6";
    sweep_pins(3);

    // R10: single tone ignores the pins
    wr(5'd3, ctrl_word(0, 3, 0, 0));
    upd();
    cur_req = "R10";
    sweep_pins(2);
    @(negedge clk) profile_sel = 4'd0;
    idle(2);
    chk("R10", 32'(amp_out), 32'h3FF);

    // R7: phase mode, sixteen levels
    wr(5'd3, ctrl_word(2, 3, 0, 0));
    upd();
    cur_req = "R7";
    sweep_pins(3);

    // R8: amplitude mode, eight levels
    wr(5'd3, ctrl_word(3, 2, 0, 0));
    upd();
    cur_req = "R8";
    sweep_pins(3);
    @(negedge clk) profile_sel = 4'd5;
    idle(3);
    chk("R8", 32'(amp_out), 32'((32'h0111_1111 * 5 + 32'h0A5A + 5 * 37) & 32'h3FF));
    @(negedge clk) profile_sel = 4'd13;
    idle(3);
    chk("R8", 32'(amp_out), 32'((32'h0111_1111 * 5 + 32'h0A5A + 5 * 37) & 32'h3FF));
    @(negedge clk) profile_sel = 4'd0;

    // R11: clear-and-hold pins the phase at the offset
    wr(5'd3, ctrl_word(0, 0, 1, 0));
    upd();
    cur_req = "R11";
    idle(10);
    chk("R11", 32'(phase_out), 32'h123);
    idle(5);
    chk("R11", 32'(phase_out), 32'h123);
    wr(5'd3, ctrl_word(0, 0, 0, 0));
    upd();
    idle(10);

    // R12: auto-clear fires once per update
    wr(5'd3, ctrl_word(1, 1, 0, 1));
    upd();
    cur_req = "R12";
    @(negedge clk) profile_sel = 4'd2;
    idle(12);
    upd();
    idle(12);
    upd();
    idle(6);

    // R13: write coinciding with the strobe waits for the next one
    cur_req = "R13";
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 32'h0000_0155; io_update = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; io_update = 1'b0;
    idle(3);
    chk("R13", 32'(amp_out), 32'h3FF);
    upd();
    idle(3);
    chk("R13", 32'(amp_out), 32'h155);
    idle(4);

    finish_run();
  end

endmodule